// File: doc/BRIEF.md
# Four-State Hard-Decision Trellis Decoder for Terminated Frames

This block recovers the information bits of a rate-1/2 convolutional code, constraint length three, from a stream of hard-decided received symbols. A frame is opened with a start pulse that also carries the frame length. The length counts the information bits plus the two zero tail bits that drive the encoder back to the all-zero state. After the start pulse, one two-bit symbol is accepted on each cycle in which the symbol strobe is high.

For each symbol the decoder runs one add-compare-select step over the four trellis states. Path metrics are accumulated Hamming distances. The per-state decisions are written into a survivor store, one row per trellis step. When the last symbol of the frame has arrived, a traceback walks the stored decisions from the final step back to the first, starting in the all-zero state. It keeps the recovered bits in a small buffer. The data bits are then sent out oldest-first with a valid strobe, and a one-cycle completion pulse follows.

The tail bits are not sent out. While a frame is being received or decoded, further start pulses have no effect.

Top module: `viterbi_frame_dec`

## Requirements
- R1: Encoder model: state is {newest input, older input}. For input u from state {m1,m2}, the register is {u,m1,m2}. The first code bit is u^m1^m2 (generator 111) and the second is u^m2 (generator 101). `sym[1]` carries the first code bit and `sym[0]` the second.
- R2: `frame_len` is the total number of steps N, with 3 <= N <= 60, of which the last two are zero tail bits. Exactly N-2 bits are emitted on `bit_out`, each with `bit_valid` high, in the order they were encoded.
- R3: A frame received without errors is decoded to exactly the encoded data bits.
- R4: A frame whose received symbols contain isolated bit errors, spaced well apart, is decoded to the encoded data bits.
- R5: The trellis begins in state 00. At frame start the metric of state 00 is zero and every other state starts unreachable.
- R6: When the two candidate paths into a state have equal accumulated distance, the path from the lower-numbered predecessor state is kept.
- R7: Traceback starts from state 00 at the final step. The decoded bit for each step is the newest-input bit of the state reached at that step.
- R8: `frame_done` is high for exactly one cycle, in the cycle directly after the last `bit_valid`. `busy` drops in the following cycle.
- R9: A start pulse while `busy` is high is ignored. The frame in progress keeps its length and its result.
- R10: A new frame is accepted as soon as `busy` is low again, and it decodes independently of the previous frame.
- R11: After reset, `busy`, `bit_valid` and `frame_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Frame start pulse, taken only while idle |
| frame_len | input | 6 | Steps in the frame including the two tail bits, sampled with `start` |
| sym_valid | input | 1 | Received symbol strobe |
| sym | input | 2 | Received hard symbol: [1] first code bit, [0] second code bit |
| busy | output | 1 | Frame being received, traced back or emitted |
| bit_valid | output | 1 | `bit_out` holds a decoded data bit |
| bit_out | output | 1 | Decoded data bit, oldest first |
| frame_done | output | 1 | One-cycle pulse after the last decoded bit |

## Verification
A start pulse can land in the same cycle as the acceptance of a symbol in the add-compare-select step. It can also land in a cycle of the traceback. Both cases are provoked by raising `start` with a different short length, once together with a mid-frame symbol and once during the decode wait. The outcome is judged at the outputs: the bit count must equal the original length minus two, the bits must match the encoded data, and `busy` must fall after `frame_done` with no new frame opened. The tie rule is exercised with a hand-built four-step received sequence in which the two survivors entering state 00 at the last step carry equal distance. The lower-predecessor choice yields all-zero data there, and the other choice would yield ones.

// File: rtl/vit_pkg.sv
package vit_pkg;

  typedef enum logic [1:0] {
    FR_IDLE,
    FR_RECV,
    FR_TRACE
  } frame_state_t;

  typedef enum logic [1:0] {
    TB_IDLE,
    TB_WALK,
    TB_EMIT,
    TB_END
  } trace_state_t;

  // Hamming distance between a received symbol and the two code bits
  // produced by the shift register contents under the two generators.
  function automatic logic [1:0] branch_dist(input logic [7:0] regv,
                                             input logic [7:0] g_a,
                                             input logic [7:0] g_b,
                                             input logic [1:0] rx);
    logic v_a, v_b;
    v_a = ^(regv & g_a);
    v_b = ^(regv & g_b);
    return {1'b0, v_a ^ rx[1]} + {1'b0, v_b ^ rx[0]};
  endfunction

endpackage

// File: rtl/vit_acs.sv
module vit_acs
  import vit_pkg::*;
#(
  parameter int K        = 3,
  parameter int G0       = 7,
  parameter int G1       = 5,
  parameter int METRIC_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    init,
  input  logic                    step,
  input  logic [1:0]              sym,
  output logic [(1<<(K-1))-1:0]   dec
);
  localparam int S    = K - 1;
  localparam int NS   = 1 << S;
  localparam int HALF = NS / 2;
  localparam logic [METRIC_W-1:0] UNREACH = METRIC_W'(1 << (METRIC_W - 2));
  localparam logic [7:0] GA = 8'(G0);
  localparam logic [7:0] GB = 8'(G1);

  logic [METRIC_W-1:0] pm  [NS];
  logic [METRIC_W-1:0] nxt [NS];

  for (genvar s = 0; s < NS; s++) begin : g_state
    localparam int P_LO = (s % HALF) * 2;
    localparam int P_HI = P_LO + 1;
    localparam int U    = s / HALF;
    logic [1:0]          d_lo, d_hi;
    logic [METRIC_W-1:0] c_lo, c_hi;
    assign d_lo   = branch_dist(8'((U << S) | P_LO), GA, GB, sym);
    assign d_hi   = branch_dist(8'((U << S) | P_HI), GA, GB, sym);
    assign c_lo   = pm[P_LO] + METRIC_W'(d_lo);
    assign c_hi   = pm[P_HI] + METRIC_W'(d_hi);
    // strict less-than: equal weights keep the lower predecessor
    assign dec[s] = (c_hi < c_lo);
    assign nxt[s] = dec[s] ? c_hi : c_lo;
  end

  always_ff @(posedge clk) begin
    if (rst || init) begin
      for (int i = 0; i < NS; i++) pm[i] <= (i == 0) ? '0 : UNREACH;
    end else if (step) begin
      for (int i = 0; i < NS; i++) pm[i] <= nxt[i];
    end
  end

endmodule

// File: rtl/vit_surv_mem.sv
module vit_surv_mem #(
  parameter int DEPTH = 60,
  parameter int WIDTH = 4,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/vit_traceback.sv
module vit_traceback
  import vit_pkg::*;
#(
  parameter int S       = 2,
  parameter int MAX_LEN = 60,
  localparam int NS     = 1 << S,
  localparam int LEN_W  = $clog2(MAX_LEN + 1),
  localparam int AW     = $clog2(MAX_LEN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [LEN_W-1:0] len,
  input  logic [NS-1:0]    rd_data,
  output logic             rd_en,
  output logic [AW-1:0]    rd_addr,
  output logic             bit_valid,
  output logic             bit_out,
  output logic             done
);
  trace_state_t       tst;
  logic [LEN_W-1:0]   issue_left;
  logic [AW-1:0]      ra, pidx, oidx, last_idx;
  logic               pend;
  logic [S-1:0]       cur;
  logic [MAX_LEN-1:0] bitbuf;

  assign rd_en   = (tst == TB_WALK) && (issue_left != '0);
  assign rd_addr = ra;

  always_ff @(posedge clk) begin
    if (rst) begin
      tst        <= TB_IDLE;
      bit_valid  <= 1'b0;
      bit_out    <= 1'b0;
      done       <= 1'b0;
      pend       <= 1'b0;
      pidx       <= '0;
      ra         <= '0;
      issue_left <= '0;
      cur        <= '0;
      oidx       <= '0;
      last_idx   <= '0;
    end else begin
      bit_valid <= 1'b0;
      done      <= 1'b0;
      pend      <= rd_en;
      pidx      <= ra;
      case (tst)
        TB_IDLE: if (go) begin
          tst        <= TB_WALK;
          issue_left <= len;
          ra         <= AW'(len - LEN_W'(1));
          last_idx   <= AW'(len - LEN_W'(3));
          cur        <= '0;
          oidx       <= '0;
        end
        TB_WALK: begin
          if (rd_en) begin
            issue_left <= issue_left - LEN_W'(1);
            ra         <= ra - AW'(1);
          end
          if (pend) begin
            bitbuf[pidx] <= cur[S-1];
            cur          <= S'({cur, rd_data[cur]});
            if (pidx == '0) tst <= TB_EMIT;
          end
        end
        TB_EMIT: begin
          bit_valid <= 1'b1;
          bit_out   <= bitbuf[oidx];
          oidx      <= oidx + AW'(1);
          if (oidx == last_idx) tst <= TB_END;
        end
        default: begin
          done <= 1'b1;
          tst  <= TB_IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/viterbi_frame_dec.sv
module viterbi_frame_dec
  import vit_pkg::*;
#(
  parameter int K        = 3,
  parameter int G0       = 7,
  parameter int G1       = 5,
  parameter int MAX_LEN  = 60,
  parameter int METRIC_W = 8,
  localparam int S       = K - 1,
  localparam int NS      = 1 << S,
  localparam int LEN_W   = $clog2(MAX_LEN + 1),
  localparam int AW      = $clog2(MAX_LEN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [LEN_W-1:0] frame_len,
  input  logic             sym_valid,
  input  logic [1:0]       sym,
  output logic             busy,
  output logic             bit_valid,
  output logic             bit_out,
  output logic             frame_done
);
  frame_state_t     st;
  logic [LEN_W-1:0] len_q, cnt;
  logic             tb_go, acs_init, acs_step;
  logic [NS-1:0]    dec, rd_data;
  logic             rd_en;
  logic [AW-1:0]    rd_addr;

  assign acs_init = (st == FR_IDLE) && start;
  assign acs_step = (st == FR_RECV) && sym_valid;
  assign busy     = (st != FR_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= FR_IDLE;
      len_q <= '0;
      cnt   <= '0;
      tb_go <= 1'b0;
    end else begin
      tb_go <= 1'b0;
      case (st)
        FR_IDLE: if (start) begin
          st    <= FR_RECV;
          len_q <= frame_len;
          cnt   <= '0;
        end
        FR_RECV: if (sym_valid) begin
          cnt <= cnt + LEN_W'(1);
          if (cnt == len_q - LEN_W'(1)) begin
            st    <= FR_TRACE;
            tb_go <= 1'b1;
          end
        end
        default: if (frame_done) st <= FR_IDLE;
      endcase
    end
  end

  vit_acs #(.K(K), .G0(G0), .G1(G1), .METRIC_W(METRIC_W)) u_acs (
    .clk  (clk),
    .rst  (rst),
    .init (acs_init),
    .step (acs_step),
    .sym  (sym),
    .dec  (dec)
  );

  vit_surv_mem #(.DEPTH(MAX_LEN), .WIDTH(NS)) u_mem (
    .clk   (clk),
    .we    (acs_step),
    .waddr (AW'(cnt)),
    .wdata (dec),
    .re    (rd_en),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  vit_traceback #(.S(S), .MAX_LEN(MAX_LEN)) u_tb (
    .clk       (clk),
    .rst       (rst),
    .go        (tb_go),
    .len       (len_q),
    .rd_data   (rd_data),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .bit_valid (bit_valid),
    .bit_out   (bit_out),
    .done      (frame_done)
  );

endmodule

// File: rtl/vit_checker.sv
module vit_checker #(
  parameter int LEN_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic             bit_valid,
  input logic             frame_done,
  input logic [LEN_W-1:0] len_q
);
  // R8: completion pulse lasts one cycle
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done);

  // R8: completion directly follows the last emitted bit
  a_r8_done_after_bit: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> $past(bit_valid));

  // R8: decoder goes idle only right after the completion pulse
  a_r8_idle_after_done: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(frame_done));

  // R2: decoded bits appear only inside a frame
  a_r2_bits_in_frame: assert property (@(posedge clk) disable iff (rst)
    bit_valid |-> busy);

  // R9: frame length cannot change while a frame is in progress
  a_r9_len_held: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(len_q));

endmodule

bind viterbi_frame_dec vit_checker #(.LEN_W(LEN_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .busy       (busy),
  .bit_valid  (bit_valid),
  .frame_done (frame_done),
  .len_q      (len_q)
);

// File: tb/tb_viterbi_frame_dec.sv
`timescale 1ns/1ps
module tb_viterbi_frame_dec;
  logic       clk = 1'b0;
  logic       rst;
  logic       start;
  logic [5:0] frame_len;
  logic       sym_valid;
  logic [1:0] sym;
  logic       busy, bit_valid, bit_out, frame_done;

  int checks   = 0;
  int failures = 0;
  bit reported = 1'b0;

  always #2.5 clk = ~clk;

  viterbi_frame_dec dut (
    .clk(clk), .rst(rst), .start(start), .frame_len(frame_len),
    .sym_valid(sym_valid), .sym(sym), .busy(busy), .bit_valid(bit_valid),
    .bit_out(bit_out), .frame_done(frame_done)
  );

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R1 encoder model: register {u,m1,m2}, generators 111 and 101,
  // symbol i placed at rx[2i+1:2i] as {first, second}
  function automatic logic [127:0] encode(input int len, input logic [63:0] data);
    logic [127:0] rx = '0;
    logic m1 = 1'b0, m2 = 1'b0;
    for (int i = 0; i < len; i++) begin
      logic u;
      u = (i < len - 2) ? data[i] : 1'b0;
      rx[2*i+1] = u ^ m1 ^ m2;
      rx[2*i]   = u ^ m2;
      m2 = m1;
      m1 = u;
    end
    return rx;
  endfunction

  // inject: 1 = start pulse together with a mid-frame symbol and during decode
  task automatic run_frame(input int len, input logic [127:0] rx,
                           input logic [63:0] exp, input bit inject,
                           input string req);
    logic [63:0] got = '0;
    logic [63:0] mask;
    int n = 0;
    bit prev_valid = 1'b0;
    bit done_seen = 1'b0;
    bit order_ok = 1'b1;
    @(negedge clk);
    start = 1'b1; frame_len = 6'(len);
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < len; i++) begin
      sym_valid = 1'b1;
      sym = rx[2*i +: 2];
      if (inject && i == 1) begin start = 1'b1; frame_len = 6'd3; end
      @(negedge clk);
      start = 1'b0;
    end
    sym_valid = 1'b0;
    for (int c = 0; c < 400; c++) begin
      if (inject && c == 2) begin start = 1'b1; frame_len = 6'd3; end
      else start = 1'b0;
      @(negedge clk);
      if (bit_valid) begin got[n] = bit_out; n++; end
      if (frame_done) begin
        if (!prev_valid || bit_valid) order_ok = 1'b0;
        done_seen = 1'b1;
        break;
      end
      prev_valid = bit_valid;
    end
    start = 1'b0;
    mask = (64'd1 << (len - 2)) - 64'd1;
    check(done_seen, {req, " frame_done seen"}, 64'(done_seen), 64'd1);
    check(n == len - 2, {req, " R2 bit count"}, 64'(n), 64'(len - 2));
    check((got & mask) == (exp & mask), {req, " decoded bits"}, got & mask, exp & mask);
    check(order_ok, {req, " R8 done follows last bit"}, 64'(order_ok), 64'd1);
    @(negedge clk);
    check(!busy, {req, " R8 busy low after done"}, 64'(busy), 64'd0);
  endtask

  task automatic t_reset();
    check(!busy, "R11 busy after reset", 64'(busy), 64'd0);
    check(!bit_valid, "R11 bit_valid after reset", 64'(bit_valid), 64'd0);
    check(!frame_done, "R11 frame_done after reset", 64'(frame_done), 64'd0);
  endtask

  task automatic t_clean_short();
    logic [63:0] d = 64'b1011;  // bits 1,1,0,1 in send order
    run_frame(6, encode(6, d), d, 1'b0, "R3 R1 clean len6");
  endtask

  task automatic t_single_error();
    logic [63:0] d = 64'b1011;
    logic [127:0] rx = encode(6, d);
    rx[2] = ~rx[2];
    run_frame(6, rx, d, 1'b0, "R4 one error len6");
  endtask

  task automatic t_max_len();
    logic [63:0] d = 64'h02C5_A93F_0D1E_77B3;
    logic [127:0] rx = encode(60, d);
    rx[9] = ~rx[9]; rx[60] = ~rx[60]; rx[101] = ~rx[101];
    run_frame(60, rx, d, 1'b0, "R4 R2 three errors len60");
  endtask

  task automatic t_min_len();
    run_frame(3, encode(3, 64'd1), 64'd1, 1'b0, "R2 len3 data1");
    run_frame(3, encode(3, 64'd0), 64'd0, 1'b0, "R2 len3 data0");
  endtask

  task automatic t_zero_start();
    // codeword 11 10 11 received as 00 10 11: from state 00 the one-path is nearer
    logic [127:0] rx = '0;
    rx[1:0] = 2'b00; rx[3:2] = 2'b10; rx[5:4] = 2'b11;
    run_frame(3, rx, 64'd1, 1'b0, "R5 R7 start and end at 00");
  endtask

  task automatic t_tie();
    // received 11 01 00 00: both survivors into 00 at the last step weigh 3
    logic [127:0] rx = '0;
    rx[1:0] = 2'b11; rx[3:2] = 2'b01;
    run_frame(4, rx, 64'd0, 1'b0, "R6 tie lower predecessor");
  endtask

  task automatic t_ignore_start();
    logic [63:0] d = 64'h0000_0000_0000_2D6B;
    run_frame(18, encode(18, d), d, 1'b1, "R9 start ignored while busy");
  endtask

  task automatic t_back_to_back();
    logic [63:0] d1 = 64'h0000_0000_0000_00F3;
    logic [63:0] d2 = 64'h0000_0000_0000_0A5C;
    run_frame(12, encode(12, d1), d1, 1'b0, "R10 first frame");
    run_frame(14, encode(14, d2), d2, 1'b0, "R10 second frame");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    report();
  end

  initial begin
    rst = 1'b1; start = 1'b0; frame_len = '0; sym_valid = 1'b0; sym = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_clean_short();
    t_single_error();
    t_max_len();
    t_min_len();
    t_zero_start();
    t_tie();
    t_ignore_start();
    t_back_to_back();
    repeat (3) @(negedge clk);
    report();
  end

endmodule